// File: doc/BRIEF.md
# Boot Memory Remap Controller

This block is the address decoder of a small embedded system that must start from non-volatile memory but later runs with RAM at address zero, where exception vectors can be rewritten. After any reset the decoder is in a boot map. Boot memory answers at address zero, and on-chip RAM is moved to a fixed high base. Boot memory is either the on-chip NVM or an external device on chip select 0. The start-up code programs the external chip-select windows and wait states through a small synchronous register port. It then sets a cancel bit, and the decoder switches for good to the normal map: RAM at zero, on-chip NVM at a fixed base, and the programmed chip-select windows.

The decode is purely combinational from the CPU address and the held state. An access is presented with `cpu_req` and is answered in the same cycle by exactly one select, or by `abort`. There is no back-pressure: the address path has no ready signal, and every request is decoded in the cycle it appears. Register writes land on the clock edge that samples `reg_we`. An access in the same cycle still sees the old state.

Top module: `boot_remap_ctrl`

## Requirements
- R1: After `rst_n` is released the map is remapped. A request inside the first 1 MiB (0x00000000 to 0x000FFFFF) selects boot memory. A request in 0x00300000 to 0x0030FFFF asserts `ram_sel` with `wait_states` 0. Any other address asserts `abort`.
- R2: The boot choice is sampled from `boot_mode` on every clock edge while `rst_n` is low, and is never sampled while `rst_n` is high. With 0 latched, the boot window asserts `nvm_sel` with `wait_states` 0. With 1 latched, it asserts `cs_n[0]` low with `wait_states` equal to the chip select 0 wait field.
- R3: A clock edge with `wdt_rst` high returns the map to remapped mode and restores every chip-select register to its reset value. The latched boot choice is kept. `wdt_rst` takes priority over a register write on the same edge.
- R4: A write to register address 0 with data bit 0 set cancels the remap from the next cycle on. A write to that address with bit 0 clear leaves the map unchanged.
- R5: Once cancelled, the map stays normal until `rst_n` or `wdt_rst`. Writing register 0 with bit 0 clear does not bring back the boot map.
- R6: While remapped, `cs_n[NUM_CS-1:1]` stay high whatever the chip-select registers hold.
- R7: Chip-select registers written while remapped are stored, and they are used for decoding once the remap is cancelled.
- R8: A wait field written on an edge applies to the access in the next cycle, in remapped mode as well. An access in the same cycle as the write uses the old value.
- R9: In the normal map, 0x00000000 to 0x0000FFFF asserts `ram_sel`, and 0x00100000 to 0x001FFFFF asserts `nvm_sel` (both with `wait_states` 0). Otherwise the lowest-numbered enabled chip select whose window holds the address is asserted, with its wait field on `wait_states`. If nothing matches, `abort` is asserted.
- R10: `ram_sel`, `nvm_sel` and the low `cs_n` bits are at most one-hot. With `cpu_req` low, all selects and `abort` are inactive and `wait_states` is 0.
- R11: Chip select i is configured at register address 8+i. The data fields are [31:16] base address bits 31:16, [10:8] size code s (window 2^(16+s) bytes, with address bits below that ignored when matching), [4] enable, and [2:0] wait states. At reset, chip select 0 has base 0x01000000, s=4, enable 1 and wait 7. The other chip selects have base 0, s=0, enable 0 and wait 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on/external reset, active low, synchronous |
| wdt_rst | input | 1 | Watchdog reset, active high, synchronous |
| boot_mode | input | 1 | Boot memory choice, sampled only during `rst_n` low (1 = external) |
| cpu_req | input | 1 | An access is presented this cycle |
| cpu_addr | input | 32 | Access byte address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| ram_sel | output | 1 | On-chip RAM selected |
| nvm_sel | output | 1 | On-chip NVM selected |
| cs_n | output | 4 | External chip selects, active low |
| wait_states | output | 3 | Wait states for the current access |
| abort | output | 1 | Request decodes to no region |

## Verification
A watchdog reset and a remap-cancel write can arrive on the same edge. The bench drives both together and then expects the boot map to hold, with boot memory at address zero, because the watchdog must win. A second collision is a register write landing in the same cycle as an access: once for the cancel bit and once for the chip select 0 wait field. The bench requires the old map or the old wait count in that cycle and the new one in the next. The behavioural model updates its state on the same edge, and every cycle is compared against it.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W    = 32;
  localparam int WS_W      = 3;
  localparam int SIZE_W    = 3;
  localparam int GRAN_LOG2 = 16;

  localparam logic [WS_W-1:0] WS_MAX = '1;

  typedef struct packed {
    logic [ADDR_W-1:GRAN_LOG2] base;
    logic [SIZE_W-1:0]         size;
    logic                      en;
    logic [WS_W-1:0]           ws;
  } cs_cfg_t;

  // True when a and b agree on every bit at or above position lg.
  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] b,
                                  input int unsigned lg);
    return ((a ^ b) >> lg) == {ADDR_W{1'b0}};
  endfunction
endpackage

// File: rtl/remap_state.sv
module remap_state (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_rst,
  input  logic boot_mode,
  input  logic cancel_wr,
  output logic remapped,
  output logic boot_ext
);
  // Boot choice follows the pin only while the external reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) boot_ext <= boot_mode;
  end

  // One-way flag: set by any reset, cleared only by a cancel write.
  always_ff @(posedge clk) begin
    if (!rst_n || wdt_rst) remapped <= 1'b1;
    else if (cancel_wr)    remapped <= 1'b0;
  end
endmodule

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
#(
  parameter int                NUM_CS       = 4,
  parameter int                REG_AW       = 4,
  parameter logic [ADDR_W-1:0] CS0_RST_BASE = 32'h0100_0000,
  parameter logic [SIZE_W-1:0] CS0_RST_SIZE = 3'd4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wdt_rst,
  input  logic                     reg_we,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [ADDR_W-1:0]        reg_wdata,
  output logic                     cancel_wr,
  output cs_cfg_t [NUM_CS-1:0]     cfg
);
  localparam int CS_REG0 = 2 ** (REG_AW - 1);

  cs_cfg_t wr_val;
  logic    unused_bits;

  always_comb begin
    wr_val.base = reg_wdata[ADDR_W-1:GRAN_LOG2];
    wr_val.size = reg_wdata[8 +: SIZE_W];
    wr_val.en   = reg_wdata[4];
    wr_val.ws   = reg_wdata[0 +: WS_W];
  end
  assign unused_bits = ^{reg_wdata[15:11], reg_wdata[7:5], reg_wdata[3]};

  assign cancel_wr = reg_we && (reg_addr == '0) && reg_wdata[0];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    localparam logic                      RST_EN   = (i == 0);
    localparam logic [ADDR_W-1:GRAN_LOG2] RST_BASE =
      (i == 0) ? CS0_RST_BASE[ADDR_W-1:GRAN_LOG2] : '0;
    localparam logic [SIZE_W-1:0]         RST_SIZE = (i == 0) ? CS0_RST_SIZE : '0;
    localparam logic [REG_AW-1:0]         MY_ADDR  = REG_AW'(CS_REG0 + i);

    cs_cfg_t q;
    always_ff @(posedge clk) begin
      if (!rst_n || wdt_rst) begin
        q.base <= RST_BASE;
        q.size <= RST_SIZE;
        q.en   <= RST_EN;
        q.ws   <= WS_MAX;
      end else if (reg_we && reg_addr == MY_ADDR) begin
        q <= wr_val;
      end
    end
    assign cfg[i] = q;
  end
endmodule

// File: rtl/remap_decoder.sv
module remap_decoder
  import remap_pkg::*;
#(
  parameter int                NUM_CS      = 4,
  parameter logic [ADDR_W-1:0] RAM_HI_BASE = 32'h0030_0000,
  parameter int                RAM_LOG2    = 16,
  parameter int                BOOT_LOG2   = 20,
  parameter logic [ADDR_W-1:0] NVM_BASE    = 32'h0010_0000,
  parameter int                NVM_LOG2    = 20
) (
  input  logic                 cpu_req,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic                 remapped,
  input  logic                 boot_ext,
  input  cs_cfg_t [NUM_CS-1:0] cfg,
  output logic                 ram_sel,
  output logic                 nvm_sel,
  output logic [NUM_CS-1:0]    cs_n,
  output logic [WS_W-1:0]      wait_states,
  output logic                 abort
);
  logic [NUM_CS-1:0] hit;
  logic [NUM_CS-1:0] cs_on;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_hit
    assign hit[i] = cfg[i].en &&
      in_win(cpu_addr, {cfg[i].base, {GRAN_LOG2{1'b0}}},
             GRAN_LOG2 + int'(cfg[i].size));
  end

  always_comb begin
    ram_sel     = 1'b0;
    nvm_sel     = 1'b0;
    cs_on       = '0;
    wait_states = '0;
    abort       = 1'b0;
    if (cpu_req) begin
      if (remapped) begin
        if (in_win(cpu_addr, '0, BOOT_LOG2)) begin
          if (boot_ext) begin
            cs_on[0]    = 1'b1;
            wait_states = cfg[0].ws;
          end else begin
            nvm_sel = 1'b1;
          end
        end else if (in_win(cpu_addr, RAM_HI_BASE, RAM_LOG2)) begin
          ram_sel = 1'b1;
        end else begin
          abort = 1'b1;
        end
      end else begin
        if (in_win(cpu_addr, '0, RAM_LOG2)) begin
          ram_sel = 1'b1;
        end else if (in_win(cpu_addr, NVM_BASE, NVM_LOG2)) begin
          nvm_sel = 1'b1;
        end else if (|hit) begin
          // Scan downward so the lowest index is the one left standing.
          for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hit[i]) begin
              cs_on       = '0;
              cs_on[i]    = 1'b1;
              wait_states = cfg[i].ws;
            end
          end
        end else begin
          abort = 1'b1;
        end
      end
    end
  end

  assign cs_n = ~cs_on;
endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
  import remap_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int REG_AW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wdt_rst,
  input  logic                   boot_mode,
  input  logic                   cpu_req,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic                   reg_we,
  input  logic [REG_AW-1:0]      reg_addr,
  input  logic [ADDR_W-1:0]      reg_wdata,
  output logic                   ram_sel,
  output logic                   nvm_sel,
  output logic [NUM_CS-1:0]      cs_n,
  output logic [WS_W-1:0]        wait_states,
  output logic                   abort
);
  logic                 remapped_q;
  logic                 boot_ext_q;
  logic                 cancel_wr;
  cs_cfg_t [NUM_CS-1:0] cfg;

  remap_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdt_rst   (wdt_rst),
    .boot_mode (boot_mode),
    .cancel_wr (cancel_wr),
    .remapped  (remapped_q),
    .boot_ext  (boot_ext_q)
  );

  remap_cfg_regs #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdt_rst   (wdt_rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cancel_wr (cancel_wr),
    .cfg       (cfg)
  );

  remap_decoder #(.NUM_CS(NUM_CS)) u_dec (
    .cpu_req     (cpu_req),
    .cpu_addr    (cpu_addr),
    .remapped    (remapped_q),
    .boot_ext    (boot_ext_q),
    .cfg         (cfg),
    .ram_sel     (ram_sel),
    .nvm_sel     (nvm_sel),
    .cs_n        (cs_n),
    .wait_states (wait_states),
    .abort       (abort)
  );
endmodule

// File: rtl/boot_remap_checker.sv
module boot_remap_checker #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_rst,
  input logic              cpu_req,
  input logic              remapped,
  input logic              boot_ext,
  input logic              ram_sel,
  input logic              nvm_sel,
  input logic [NUM_CS-1:0] cs_n,
  input logic              abort
);
  p_wdt_remap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> remapped);

  p_boot_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_ext));

  p_one_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!remapped && !wdt_rst) |=> !remapped);

  p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    remapped |-> (&cs_n[NUM_CS-1:1]));

  p_abort_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!ram_sel && !nvm_sel && (&cs_n)));

  p_onehot_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, nvm_sel, ~cs_n}));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> (!ram_sel && !nvm_sel && !abort && (&cs_n)));
endmodule

bind boot_remap_ctrl boot_remap_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wdt_rst  (wdt_rst),
  .cpu_req  (cpu_req),
  .remapped (remapped_q),
  .boot_ext (boot_ext_q),
  .ram_sel  (ram_sel),
  .nvm_sel  (nvm_sel),
  .cs_n     (cs_n),
  .abort    (abort)
);

// File: tb/boot_remap_ctrl_test.sv
module boot_remap_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdt_rst = 1'b0;
  logic        boot_mode = 1'b0;
  logic        cpu_req = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        ram_sel, nvm_sel, abort;
  logic [3:0]  cs_n;
  logic [2:0]  wait_states;

  boot_remap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .boot_mode(boot_mode),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ram_sel(ram_sel),
    .nvm_sel(nvm_sel), .cs_n(cs_n), .wait_states(wait_states), .abort(abort)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Behavioural model state
  bit     m_remap = 1'b1;
  bit     m_boot = 1'b0;
  longint m_base[NCS];
  int     m_size[NCS];
  bit     m_en[NCS];
  int     m_ws[NCS];

  task automatic model_defaults();
    for (int i = 0; i < NCS; i++) begin
      m_base[i] = (i == 0) ? 64'h0100_0000 : 0;
      m_size[i] = (i == 0) ? 4 : 0;
      m_en[i]   = (i == 0);
      m_ws[i]   = 7;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_remap = 1'b1;
      m_boot  = boot_mode;
      model_defaults();
    end else if (wdt_rst) begin
      m_remap = 1'b1;
      model_defaults();
    end else if (reg_we) begin
      if (reg_addr == 0 && reg_wdata[0]) m_remap = 1'b0;
      for (int i = 0; i < NCS; i++) begin
        if (reg_addr == 8 + i) begin
          m_base[i] = longint'(reg_wdata[31:16]) * 65536;
          m_size[i] = int'(reg_wdata[10:8]);
          m_en[i]   = reg_wdata[4];
          m_ws[i]   = int'(reg_wdata[2:0]);
        end
      end
    end
  end

  function automatic logic [9:0] expected();
    longint a = longint'(cpu_addr);
    bit r = 0, n = 0, ab = 0;
    int cs = -1, ws = 0;
    logic [3:0] csn;
    if (cpu_req) begin
      if (m_remap) begin
        if (a < 64'h10_0000) begin
          if (m_boot) begin cs = 0; ws = m_ws[0]; end
          else n = 1;
        end else if (a >= 64'h30_0000 && a < 64'h31_0000) r = 1;
        else ab = 1;
      end else begin
        if (a < 64'h1_0000) r = 1;
        else if (a >= 64'h10_0000 && a < 64'h20_0000) n = 1;
        else begin
          for (int i = 0; i < NCS; i++) begin
            longint sz = longint'(1) << (16 + m_size[i]);
            longint lo = m_base[i] - (m_base[i] % sz);
            if (cs < 0 && m_en[i] && a >= lo && a < lo + sz) begin
              cs = i; ws = m_ws[i];
            end
          end
          if (cs < 0) ab = 1;
        end
      end
    end
    csn = 4'hF;
    if (cs >= 0) csn[cs] = 1'b0;
    return {r, n, csn, 3'(ws), ab};
  endfunction

  // Compared every cycle, halfway between edges.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [9:0] exp_v, act_v;
      exp_v = expected();
      act_v = {ram_sel, nvm_sel, cs_n, wait_states, abort};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s addr=%h req=%b: got ram/nvm/cs_n/ws/abort=%b expected %b",
                 cur_req, cpu_addr, cpu_req, act_v, exp_v);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic acc(input logic [31:0] a);
    cpu_req = 1'b1; cpu_addr = a; tick(); cpu_req = 1'b0;
  endtask

  task automatic wr(input logic [3:0] ra, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = ra; reg_wdata = d; tick(); reg_we = 1'b0;
  endtask

  function automatic logic [31:0] cfgw(input logic [31:0] base, input int sz,
                                       input bit en, input int ws);
    return {base[31:16], 5'b0, 3'(sz), 3'b0, en, 1'b0, 3'(ws)};
  endfunction

  task automatic do_reset(input bit bm);
    rst_n = 1'b0; boot_mode = bm;
    repeat (3) tick();
    rst_n = 1'b1; boot_mode = ~bm;  // pin change after release must be ignored (R2)
    tick();
  endtask

  function automatic logic [31:0] sweep_addr(input int k);
    logic [31:0] b;
    case (k % 8)
      0: b = 32'h0000_0000; 1: b = 32'h0010_0000; 2: b = 32'h0100_0000;
      3: b = 32'h0200_0000; 4: b = 32'h0201_0000; 5: b = 32'h0400_0000;
      6: b = 32'h0030_0000; default: b = 32'h0800_0000;
    endcase
    return b + ((k * 32'h1357) & 32'h0003_FFFF);
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: boot map after power-on reset, internal boot
    do_reset(1'b0);
    cur_req = "R1";
    acc(32'h0000_0000); acc(32'h000F_FFFC); acc(32'h0030_0004);
    acc(32'h0031_0000); acc(32'h0100_0000);
    cur_req = "R10";
    tick(); tick();

    // R6 / R7: program windows during boot; they must not decode yet
    cur_req = "R7";
    wr(4'd9,  cfgw(32'h0200_0000, 0, 1, 1));
    wr(4'd10, cfgw(32'h0200_0000, 1, 1, 5));
    wr(4'd11, cfgw(32'h0400_0000, 2, 0, 3));
    cur_req = "R6";
    acc(32'h0200_0000); acc(32'h0201_0000); acc(32'h0100_0000);

    // R4: writing 0 is ignored, writing 1 cancels
    cur_req = "R4";
    wr(4'd0, 32'h0000_0000);
    acc(32'h0000_0000); acc(32'h0030_0000);
    wr(4'd0, 32'h0000_0001);
    acc(32'h0000_0000); acc(32'h0030_0000);

    // R9 / R11: normal map, priority, abort, reset config of chip select 0
    cur_req = "R9";
    acc(32'h0200_0000); acc(32'h0201_0000); acc(32'h0100_0000);
    acc(32'h010F_FFFF); acc(32'h0110_0000); acc(32'h0010_0000);
    acc(32'h0400_0000); acc(32'h0000_FFFF); acc(32'h0001_0000);
    cur_req = "R11";
    wr(4'd11, cfgw(32'h0400_0000, 2, 1, 3));
    acc(32'h0403_FFFC); acc(32'h0404_0000);

    // R5: the remap cannot be restored by a write
    cur_req = "R5";
    wr(4'd0, 32'h0000_0000);
    acc(32'h0000_0000);
    wr(4'd0, 32'hFFFF_FFFE);
    acc(32'h0000_0000);

    cur_req = "R9";
    for (int k = 0; k < 48; k++) acc(sweep_addr(k));

    // R3: watchdog and cancel write on the same edge, watchdog wins
    cur_req = "R3";
    wdt_rst = 1'b1; reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h1;
    tick();
    wdt_rst = 1'b0; reg_we = 1'b0;
    acc(32'h0000_0000); acc(32'h0030_0000);
    wr(4'd0, 32'h1);
    acc(32'h0200_0000);  // config was restored: chip select 1 disabled

    // R2: external boot latched during reset
    cur_req = "R2";
    do_reset(1'b1);
    acc(32'h0000_0000); acc(32'h0008_0000);

    // R8: wait-state write in the same cycle as an access, then next access
    cur_req = "R8";
    cpu_req = 1'b1; cpu_addr = 32'h0000_0010;
    reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = cfgw(32'h0100_0000, 4, 1, 2);
    tick();
    reg_we = 1'b0;
    tick();
    cpu_req = 1'b0;
    acc(32'h0000_0000);

    // R3: watchdog keeps external boot even with boot_mode now 0
    cur_req = "R3";
    boot_mode = 1'b0;
    wdt_rst = 1'b1; tick(); wdt_rst = 1'b0;
    acc(32'h0000_0000); acc(32'h0000_0100);

    // R4: cancel write and access in the same cycle
    cur_req = "R4";
    cpu_req = 1'b1; cpu_addr = 32'h0000_0000;
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h1;
    tick();
    reg_we = 1'b0;
    tick();
    cpu_req = 1'b0;

    cur_req = "R9";
    for (int k = 0; k < 24; k++) acc(sweep_addr(k + 5));

    cur_req = "R10";
    tick(); tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule